// File: doc/BRIEF.md
# Alternating-Preamble Watcher with Dead-Channel Flag

This block sits behind a bit slicer and clock-recovery loop in a receiver. It looks at the recovered data one bit at a time, and only in cycles where the bit-valid strobe is high. It measures how long the current run of alternating ones and zeros is. When that run reaches a programmable threshold, a sticky preamble-found flag is raised. A threshold of 8 bits suits a plain receiver, and 20 bits is the usual choice when two antennas are being compared.

A frequency-hopping receiver also needs to give up on an empty channel quickly. For that, a second counter measures an evaluation window that starts when the block is enabled. The window length is set in steps of four bit periods. If the window closes before any preamble is found, a sticky dead-channel flag rises and the hop logic can move on.

Both flags are decoded from a four-state controller:

| State | Meaning |
|---|---|
| `S_IDLE` | Disabled, no search running |
| `S_HUNT` | Counting strobes and measuring the run |
| `S_FOUND` | Preamble seen |
| `S_EXPIRED` | Window closed without a preamble |

The controller moves between states as follows:

| Transition | Condition |
|---|---|
| IDLE→HUNT | Rising edge of enable |
| HUNT→IDLE | Enable low |
| HUNT→FOUND | The run reaches the threshold |
| HUNT→EXPIRED | The window closes without a preamble |
| FOUND/EXPIRED→HUNT | Rising edge of enable, or flag clear while enabled |
| FOUND/EXPIRED→IDLE | Flag clear while disabled |

Top module: `pream_watch`

## Requirements
- R1: After reset both `det_flag` and `inv_flag` are 0.
- R2: With threshold T in `det_thresh` (1..31, where 0 acts as 1), `det_flag` rises in the cycle after the T-th consecutive alternating strobed bit, and not earlier.
- R3: A strobed bit equal to the previous strobed bit breaks the run: that bit begins a new run of length 1.
- R4: With W = `inv_win` (1..15), `inv_flag` rises in the cycle after the (4·W)-th strobe counted since the search restarted, provided no preamble was found by then.
- R5: `inv_win` = 0 disables the window, and `inv_flag` never rises.
- R6: If a strobe both completes the threshold and closes the window, `det_flag` wins. The two flags are never both 1. Once either flag is set, later strobes change neither flag.
- R7: Only cycles with `bit_vld` = 1 are counted, and `bit_in` is ignored in all other cycles.
- R8: Flags stay set until `flag_clr` is pulsed. A clear drops both flags and, if enabled, starts a fresh search with the run and the window at zero.
- R9: While `enable` = 0, strobes are ignored and any set flag holds. A rising edge of `enable` clears the flags and restarts both counters, and a strobe in that same cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Search enable; its rising edge restarts the search |
| bit_vld | input | 1 | Strobe marking a valid recovered bit |
| bit_in | input | 1 | Recovered data bit |
| det_thresh | input | 5 | Alternating-run length required for detection, in bits |
| inv_win | input | 4 | Window length in units of four bit periods (0 = off) |
| flag_clr | input | 1 | Clears both flags |
| det_flag | output | 1 | Sticky preamble-found flag |
| inv_flag | output | 1 | Sticky dead-channel flag |

## Verification
The hardest case to reach is the single strobe on which the run reaches the threshold and the window closes at the same moment. To get there, the bench pairs a threshold of 8 with a window of 2, so both limits fall on the eighth strobe. It then repeats the setup with a threshold of 9 to show the window winning by one bit. Run breaks are swept over every position inside a threshold-8 run and a threshold-20 run, so the restart-at-one rule is tested at each position and not only at the edges.

// File: rtl/pd_pkg.sv
package pd_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_HUNT    = 2'd1,
        S_FOUND   = 2'd2,
        S_EXPIRED = 2'd3
    } pd_state_e;
endpackage

// File: rtl/pd_run_cnt.sv
// Measures the current alternating run; flags the strobe that reaches threshold.
module pd_run_cnt #(
    parameter int THR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic             bit_in,
    input  logic [THR_W-1:0] thresh,
    output logic             hit
);
    logic [THR_W-1:0] run_q, run_d, thr_eff;
    logic             prev_q, have_q;

    always_comb begin
        thr_eff = (thresh == '0) ? THR_W'(1) : thresh;
        if (!have_q || (bit_in != prev_q)) begin
            run_d = (run_q >= thr_eff) ? run_q : run_q + THR_W'(1);
        end else begin
            run_d = THR_W'(1);
        end
        hit = step && (run_d >= thr_eff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            prev_q <= 1'b0;
            have_q <= 1'b0;
        end else if (restart) begin
            run_q  <= '0;
            prev_q <= 1'b0;
            have_q <= 1'b0;
        end else if (step) begin
            run_q  <= run_d;
            prev_q <= bit_in;
            have_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pd_win_tmr.sv
// Counts strobes since restart; flags the strobe that closes the window.
module pd_win_tmr #(
    parameter int WIN_W    = 4,
    parameter int WIN_MULT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic [WIN_W-1:0] win,
    output logic             expire
);
    localparam int MAX_WIN = ((1 << WIN_W) - 1) * WIN_MULT;
    localparam int TMR_W   = $clog2(MAX_WIN + 1);

    logic [TMR_W-1:0] tmr_q, tmr_inc, limit;

    always_comb begin
        tmr_inc = (tmr_q == TMR_W'(MAX_WIN)) ? tmr_q : tmr_q + TMR_W'(1);
        limit   = TMR_W'(win) * TMR_W'(WIN_MULT);
        expire  = step && (win != '0) && (tmr_inc == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tmr_q <= '0;
        else if (restart) tmr_q <= '0;
        else if (step)    tmr_q <= tmr_inc;
    end
endmodule

// File: rtl/pd_ctrl.sv
// Search controller: state register, next-state logic, output decode.
module pd_ctrl
    import pd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_vld,
    input  logic flag_clr,
    input  logic hit,
    input  logic expire,
    output logic step,
    output logic restart,
    output logic det_flag,
    output logic inv_flag
);
    pd_state_e state_q, state_d;
    logic      en_q, en_rise;

    assign en_rise = enable && !en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= enable;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (en_rise) state_d = S_HUNT;
            end
            S_HUNT: begin
                if (!enable)     state_d = S_IDLE;
                else if (hit)    state_d = S_FOUND;
                else if (expire) state_d = S_EXPIRED;
            end
            S_FOUND, S_EXPIRED: begin
                if (en_rise)       state_d = S_HUNT;
                else if (flag_clr) state_d = enable ? S_HUNT : S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        step     = (state_q == S_HUNT) && enable && bit_vld && !en_rise;
        restart  = en_rise
                 || (flag_clr && ((state_q == S_FOUND) || (state_q == S_EXPIRED)));
        det_flag = (state_q == S_FOUND);
        inv_flag = (state_q == S_EXPIRED);
    end
endmodule

// File: rtl/pream_watch.sv
module pream_watch #(
    parameter int THR_W    = 5,
    parameter int WIN_W    = 4,
    parameter int WIN_MULT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             bit_vld,
    input  logic             bit_in,
    input  logic [THR_W-1:0] det_thresh,
    input  logic [WIN_W-1:0] inv_win,
    input  logic             flag_clr,
    output logic             det_flag,
    output logic             inv_flag
);
    logic step, restart, hit, expire;

    pd_run_cnt #(.THR_W(THR_W)) u_run (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(step),
        .bit_in(bit_in), .thresh(det_thresh), .hit(hit)
    );

    pd_win_tmr #(.WIN_W(WIN_W), .WIN_MULT(WIN_MULT)) u_tmr (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(step),
        .win(inv_win), .expire(expire)
    );

    pd_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bit_vld(bit_vld),
        .flag_clr(flag_clr), .hit(hit), .expire(expire), .step(step),
        .restart(restart), .det_flag(det_flag), .inv_flag(inv_flag)
    );
endmodule

// File: rtl/pd_check.sv
module pd_check #(
    parameter int THR_W = 5,
    parameter int WIN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             bit_vld,
    input logic             bit_in,
    input logic [THR_W-1:0] det_thresh,
    input logic [WIN_W-1:0] inv_win,
    input logic             flag_clr,
    input logic             det_flag,
    input logic             inv_flag
);
    logic en_d;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_d <= 1'b0;
        else        en_d <= enable;
    end

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(det_flag && inv_flag)); // R6

    AST_DET_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_flag) |-> $past(bit_vld) && $past(enable)); // R7

    AST_INV_OFF_WHEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inv_flag) |-> $past(inv_win) != '0); // R5

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && (det_flag || inv_flag) |=> !det_flag && !inv_flag); // R8

    AST_DET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        det_flag && !flag_clr && !(enable && !en_d) |=> det_flag); // R9

    AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        enable && !en_d |=> !det_flag && !inv_flag); // R9
endmodule

bind pream_watch pd_check #(.THR_W(THR_W), .WIN_W(WIN_W)) u_chk (.*);

// File: tb/tb_pream_watch.sv
module tb_pream_watch;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, bit_vld = 1'b0, bit_in = 1'b0, flag_clr = 1'b0;
    logic [4:0] det_thresh = 5'd8;
    logic [3:0] inv_win = 4'd0;
    logic       det_flag, inv_flag;
    int         errors = 0, checks = 0;
    bit         done = 1'b0;

    pream_watch dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic b);
        @(negedge clk); bit_vld = 1'b1; bit_in = b;
        @(negedge clk); bit_vld = 1'b0;
    endtask

    task automatic restart(input logic [4:0] t, input logic [3:0] w);
        @(negedge clk); enable = 1'b0; det_thresh = t; inv_win = w;
        @(negedge clk); enable = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 det after reset", det_flag, 1'b0);
        chk("R1 inv after reset", inv_flag, 1'b0);
        rst_n = 1'b1;

        // R2: threshold sweep with a clean alternating stream
        for (int t = 1; t <= 31; t++) begin
            restart(5'(t), 4'd0);
            for (int i = 1; i <= t; i++) begin
                strobe(1'(i & 1));
                if (i == t - 1) chk("R2 early", det_flag, 1'b0);
                if (i == t)     chk("R2 at threshold", det_flag, 1'b1);
            end
            chk("R2 inv quiet", inv_flag, 1'b0);
        end

        // R3: break at every position p; detection lands at p+T
        for (int tt = 0; tt < 2; tt++) begin
            int t;
            t = (tt == 0) ? 8 : 20;
            for (int p = 1; p < t; p++) begin
                logic b;
                restart(5'(t), 4'd0);
                b = 1'b0;
                for (int i = 1; i <= p + t; i++) begin
                    if (i > 1 && i != p + 1) b = ~b;
                    strobe(b);
                    if (i == p + t - 1) chk("R3 no early detect", det_flag, 1'b0);
                    if (i == p + t)     chk("R3 detect after break", det_flag, 1'b1);
                end
            end
        end

        // R4: window sweep with a constant stream
        for (int w = 1; w <= 15; w++) begin
            restart(5'd31, 4'(w));
            for (int i = 1; i <= 4 * w; i++) begin
                strobe(1'b1);
                if (i == 4 * w - 1) chk("R4 early", inv_flag, 1'b0);
                if (i == 4 * w)     chk("R4 window close", inv_flag, 1'b1);
            end
            strobe(1'b0); strobe(1'b1);
            chk("R6 det ignored after expiry", det_flag, 1'b0);
            chk("R6 inv held", inv_flag, 1'b1);
        end

        // R5: window off
        restart(5'd2, 4'd0);
        for (int i = 0; i < 70; i++) strobe(1'b0);
        chk("R5 inv never", inv_flag, 1'b0);
        chk("R5 det none", det_flag, 1'b0);

        // R6: tie goes to detection; threshold 9 loses to window of 8
        restart(5'd8, 4'd2);
        for (int i = 1; i <= 8; i++) strobe(1'(i & 1));
        chk("R6 tie det", det_flag, 1'b1);
        chk("R6 tie inv", inv_flag, 1'b0);
        restart(5'd9, 4'd2);
        for (int i = 1; i <= 9; i++) begin
            strobe(1'(i & 1));
            if (i == 8) chk("R6 window first", inv_flag, 1'b1);
        end
        chk("R6 late det blocked", det_flag, 1'b0);

        // R7: idle cycles with bit_in repeating must not count
        restart(5'd4, 4'd0);
        for (int i = 1; i <= 4; i++) begin
            strobe(1'(i & 1));
            repeat (2) @(negedge clk);
            bit_in = 1'(i & 1);
        end
        chk("R7 only strobes counted", det_flag, 1'b1);

        // R8: sticky, then clear restarts search
        repeat (5) @(negedge clk);
        chk("R8 sticky", det_flag, 1'b1);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        chk("R8 cleared", det_flag, 1'b0);
        for (int i = 1; i <= 4; i++) begin
            strobe(1'(i & 1));
            if (i == 3) chk("R8 fresh run", det_flag, 1'b0);
        end
        chk("R8 detect again", det_flag, 1'b1);

        // R9: disabled strobes ignored, flags hold, rise clears
        restart(5'd4, 4'd0);
        for (int i = 1; i <= 3; i++) strobe(1'(i & 1));
        @(negedge clk); enable = 1'b0;
        for (int i = 4; i <= 8; i++) strobe(1'(i & 1));
        chk("R9 ignored while off", det_flag, 1'b0);
        @(negedge clk); enable = 1'b1; bit_vld = 1'b1; bit_in = 1'b1;
        @(negedge clk); bit_vld = 1'b0;
        for (int i = 1; i <= 4; i++) begin
            strobe(1'(i & 1));
            if (i == 3) chk("R9 rise strobe not counted", det_flag, 1'b0);
        end
        chk("R9 detect after rise", det_flag, 1'b1);
        @(negedge clk); enable = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 hold while off", det_flag, 1'b1);
        enable = 1'b1; @(negedge clk);
        chk("R9 rise clears", det_flag, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule